// File: doc/BRIEF.md
# Programmable Up-Counting Timer with Match and PWM

This block is a general-purpose up-counting timer driven entirely by one functional clock. Software programs it through a small synchronous register interface: a control word, the live counter, a reload value, a compare value, a reload strobe, an interrupt status word with write-one-to-clear bits and an interrupt enable word. The counter advances on every clock, or on a power-of-two divided tick, while its start bit is set. When it passes its all-ones value it either reloads and keeps running or stops.

Two events are produced: overflow and compare match. Each one sets a status bit, and a single interrupt line is driven from the enabled status bits. The same events can drive a PWM output, which either inverts on every selected event or shows a one-clock pulse away from a programmable idle level. A soft reset is started by writing a fixed key. A ready bit reads low until the soft reset has finished.

Register addresses (word index on `wr_addr`/`rd_addr`): 0 reset status (bit 0 = ready), 1 soft-reset key, 2 control, 3 counter, 4 reload value, 5 compare value, 6 reload strobe, 7 interrupt status, 8 interrupt enable. Control bits: 0 start, 1 auto-reload, 4:2 prescale value N, 5 prescale enable, 6 compare enable, 7 PWM idle level, 11:10 PWM event select, 12 PWM toggle mode. Unused addresses read zero.

Top module: `tmr_core`

## Requirements
- R1: The counter steps by one on each tick only while control bit 0 (start) is 1; with start at 0 its value holds.
- R2: With control bit 5 at 1 and bits 4:2 holding N, the counter steps once every 2^(N+1) clocks after start is set; with bit 5 at 0 it steps on every clock, whatever bits 4:2 hold.
- R3: With control bit 1 (auto-reload) at 1, a step from the all-ones value loads the counter from the reload register (address 4), and start stays 1.
- R4: With control bit 1 at 0, a step from the all-ones value leaves the counter at 0 and clears control bit 0.
- R5: Any write to address 6 loads the counter with the reload register value on the next clock, whatever the data.
- R6: A write to address 3 sets the counter, and reading address 3 returns the live counter value.
- R7: With control bit 6 at 1, a counting step that brings the counter to the compare value (address 5) sets status bit 0 (address 7); with bit 6 at 0 it does not.
- R8: An overflow sets status bit 1. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R9: `irq` is 1 exactly while some status bit and the matching enable bit (address 8, bit 0 match, bit 1 overflow) are both 1.
- R10: Control bits 11:10 select the PWM events: 00 none, 01 overflow, 10 overflow and match, 11 match only. With bit 12 at 1, `pwm_out` inverts on each selected event.
- R11: With bit 12 at 0, `pwm_out` sits at the idle level in control bit 7 and takes the opposite level for one clock after each selected event.
- R12: Writing exactly 0x06 to address 1 clears every register and holds ready (address 0 bit 0) low for RST_CYCLES clocks; any other value there has no effect.
- R13: After `rst_n` is released, all registers read 0 except ready, which reads 1, and `irq` and `pwm_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write word address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | ADDR_W | Register read word address |
| rd_data | output | CNT_W | Read data for rd_addr, same cycle |
| irq | output | 1 | Interrupt, level |
| pwm_out | output | 1 | PWM / event output |

## Verification
The bench builds the core with CNT_W = 32, ADDR_W = 4 and RST_CYCLES = 4. The full 32-bit width puts the all-ones wrap in the bench's reach by writing the counter a few steps below it. The short soft-reset window lets the bench sample both sides of the ready edge within a handful of clocks. Prescale values 0, 1 and 2 are exercised with the divider on and off, so the 2^(N+1) step spacing can be told apart from a plain per-clock count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   // register word addresses
   localparam int ADR_RDY   = 0;
   localparam int ADR_KEY   = 1;
   localparam int ADR_CTRL  = 2;
   localparam int ADR_CNT   = 3;
   localparam int ADR_LOAD  = 4;
   localparam int ADR_MATCH = 5;
   localparam int ADR_TRIG  = 6;
   localparam int ADR_ISTAT = 7;
   localparam int ADR_IEN   = 8;

   // control word layout
   localparam int CTRL_W    = 13;
   localparam int B_START   = 0;
   localparam int B_AUTO    = 1;
   localparam int B_PRE_LO  = 2;
   localparam int B_PRE_HI  = 4;
   localparam int B_PRE_EN  = 5;
   localparam int B_CMP_EN  = 6;
   localparam int B_IDLE    = 7;
   localparam int B_SEL_LO  = 10;
   localparam int B_SEL_HI  = 11;
   localparam int B_TOGGLE  = 12;
   localparam int PRE_W     = B_PRE_HI - B_PRE_LO + 1;

   // interrupt sources
   localparam int IRQ_N     = 2;
   localparam int IRQ_MATCH = 0;
   localparam int IRQ_OVF   = 1;

   localparam int SOFT_KEY  = 6;

   typedef enum logic [1:0] {
      PWM_NONE  = 2'b00,
      PWM_OVF   = 2'b01,
      PWM_BOTH  = 2'b10,
      PWM_MATCH = 2'b11
   } pwm_sel_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int PW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          run,
   input  logic          pre_en,
   input  logic [PW-1:0] pre_val,
   output logic          tick
);
   localparam int DIV_W = 1 << PW;

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] mask;

   generate
      if (PW < 1 || PW > 5) begin : g_bad_pw
         $error("tmr_prescale: PW out of range");
      end
   endgenerate

   always_comb begin
      mask = DIV_W'((64'd2 << pre_val) - 64'd1);
      tick = run & (~pre_en | ((div_q & mask) == mask));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          div_q <= '0;
      else if (clr || !run) div_q <= '0;
      else                 div_q <= div_q + 1'b1;
   end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          tick,
   input  logic          auto_rl,
   input  logic          cmp_en,
   input  logic [CW-1:0] load_val,
   input  logic [CW-1:0] match_val,
   input  logic          wr_cnt,
   input  logic [CW-1:0] wr_val,
   input  logic          trig,
   output logic [CW-1:0] cnt,
   output logic          ovf_evt,
   output logic          match_evt,
   output logic          stop_req
);
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] step;
   logic          at_max;
   logic          adv;

   always_comb begin
      at_max    = &cnt_q;
      step      = cnt_q + 1'b1;
      adv       = tick & ~wr_cnt & ~trig;
      ovf_evt   = adv & at_max;
      match_evt = adv & cmp_en & ~at_max & (step == match_val);
      stop_req  = ovf_evt & ~auto_rl;
      cnt       = cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clr)     cnt_q <= '0;
      else if (wr_cnt)  cnt_q <= wr_val;
      else if (trig)    cnt_q <= load_val;
      else if (adv) begin
         if (at_max) cnt_q <= auto_rl ? load_val : '0;
         else        cnt_q <= step;
      end
   end
endmodule

// File: rtl/tmr_pwm.sv
module tmr_pwm
   import tmr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic [1:0] sel,
   input  logic       toggle,
   input  logic       idle_lvl,
   input  logic       ovf_evt,
   input  logic       match_evt,
   output logic       pwm
);
   logic fire;
   logic flip_q;

   always_comb begin
      unique case (pwm_sel_e'(sel))
         PWM_NONE:  fire = 1'b0;
         PWM_OVF:   fire = ovf_evt;
         PWM_BOTH:  fire = ovf_evt | match_evt;
         PWM_MATCH: fire = match_evt;
         default:   fire = 1'b0;
      endcase
      pwm = idle_lvl ^ flip_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flip_q <= 1'b0;
      else if (clr)    flip_q <= 1'b0;
      else if (toggle) flip_q <= flip_q ^ fire;
      else             flip_q <= fire;
   end
endmodule

// File: rtl/tmr_softrst.sv
module tmr_softrst #(
   parameter int RST_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   output logic busy
);
   localparam int SW = $clog2(RST_CYCLES + 1);

   logic [SW-1:0] n_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         n_q  <= '0;
      end else if (busy) begin
         if (n_q == SW'(RST_CYCLES - 1)) begin
            busy <= 1'b0;
            n_q  <= '0;
         end else begin
            n_q <= n_q + 1'b1;
         end
      end else if (go) begin
         busy <= 1'b1;
         n_q  <= '0;
      end
   end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
   import tmr_pkg::*;
#(
   parameter int CNT_W      = 32,
   parameter int ADDR_W     = 4,
   parameter int RST_CYCLES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [CNT_W-1:0]  rd_data,
   output logic              irq,
   output logic              pwm_out
);
   generate
      if (CNT_W < 16 || CNT_W > 64) begin : g_bad_cw
         $error("tmr_core: CNT_W must be 16..64");
      end
      if (ADDR_W < 4) begin : g_bad_aw
         $error("tmr_core: ADDR_W must be at least 4");
      end
      if (RST_CYCLES < 1) begin : g_bad_rc
         $error("tmr_core: RST_CYCLES must be at least 1");
      end
   endgenerate

   logic [CTRL_W-1:0] ctrl_q;
   logic [CNT_W-1:0]  load_q;
   logic [CNT_W-1:0]  match_q;
   logic [IRQ_N-1:0]  ien_q;
   logic [IRQ_N-1:0]  ista_q;
   logic [IRQ_N-1:0]  evt;
   logic [CNT_W-1:0]  cnt;
   logic              tick, ovf_evt, match_evt, stop_req, busy;
   logic              wr_ok, soft_go;
   logic              wr_ctrl_hit, wr_cnt_hit, trig_hit, wr_load_hit;
   logic              wr_match_hit, wr_ien_hit, wr_ista_hit, wr_key_hit;

   always_comb begin
      wr_ok        = wr_en & ~busy;
      wr_key_hit   = wr_ok & (wr_addr == ADDR_W'(ADR_KEY));
      wr_ctrl_hit  = wr_ok & (wr_addr == ADDR_W'(ADR_CTRL));
      wr_cnt_hit   = wr_ok & (wr_addr == ADDR_W'(ADR_CNT));
      wr_load_hit  = wr_ok & (wr_addr == ADDR_W'(ADR_LOAD));
      wr_match_hit = wr_ok & (wr_addr == ADDR_W'(ADR_MATCH));
      trig_hit     = wr_ok & (wr_addr == ADDR_W'(ADR_TRIG));
      wr_ista_hit  = wr_ok & (wr_addr == ADDR_W'(ADR_ISTAT));
      wr_ien_hit   = wr_ok & (wr_addr == ADDR_W'(ADR_IEN));
      soft_go      = wr_key_hit & (wr_data == CNT_W'(SOFT_KEY));
   end

   tmr_softrst #(.RST_CYCLES(RST_CYCLES)) u_srst (
      .clk(clk), .rst_n(rst_n), .go(soft_go), .busy(busy)
   );

   tmr_prescale #(.PW(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .clr(busy),
      .run(ctrl_q[B_START]), .pre_en(ctrl_q[B_PRE_EN]),
      .pre_val(ctrl_q[B_PRE_HI:B_PRE_LO]), .tick(tick)
   );

   tmr_counter #(.CW(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(busy), .tick(tick),
      .auto_rl(ctrl_q[B_AUTO]), .cmp_en(ctrl_q[B_CMP_EN]),
      .load_val(load_q), .match_val(match_q),
      .wr_cnt(wr_cnt_hit), .wr_val(wr_data), .trig(trig_hit),
      .cnt(cnt), .ovf_evt(ovf_evt), .match_evt(match_evt),
      .stop_req(stop_req)
   );

   tmr_pwm u_pwm (
      .clk(clk), .rst_n(rst_n), .clr(busy),
      .sel(ctrl_q[B_SEL_HI:B_SEL_LO]), .toggle(ctrl_q[B_TOGGLE]),
      .idle_lvl(ctrl_q[B_IDLE]), .ovf_evt(ovf_evt),
      .match_evt(match_evt), .pwm(pwm_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         load_q  <= '0;
         match_q <= '0;
         ien_q   <= '0;
      end else if (busy) begin
         ctrl_q  <= '0;
         load_q  <= '0;
         match_q <= '0;
         ien_q   <= '0;
      end else begin
         if (wr_ctrl_hit)   ctrl_q <= wr_data[CTRL_W-1:0];
         else if (stop_req) ctrl_q[B_START] <= 1'b0;
         if (wr_load_hit)   load_q  <= wr_data;
         if (wr_match_hit)  match_q <= wr_data;
         if (wr_ien_hit)    ien_q   <= wr_data[IRQ_N-1:0];
      end
   end

   always_comb begin
      evt            = '0;
      evt[IRQ_MATCH] = match_evt;
      evt[IRQ_OVF]   = ovf_evt;
   end

   generate
      for (genvar i = 0; i < IRQ_N; i++) begin : g_ista
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    ista_q[i] <= 1'b0;
            else if (busy) ista_q[i] <= 1'b0;
            else           ista_q[i] <= evt[i] |
                                        (ista_q[i] & ~(wr_ista_hit & wr_data[i]));
         end
      end
   endgenerate

   always_comb irq = |(ista_q & ien_q);

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         ADDR_W'(ADR_RDY):   rd_data[0] = ~busy;
         ADDR_W'(ADR_CTRL):  rd_data[CTRL_W-1:0] = ctrl_q;
         ADDR_W'(ADR_CNT):   rd_data = cnt;
         ADDR_W'(ADR_LOAD):  rd_data = load_q;
         ADDR_W'(ADR_MATCH): rd_data = match_q;
         ADDR_W'(ADR_ISTAT): rd_data[IRQ_N-1:0] = ista_q;
         ADDR_W'(ADR_IEN):   rd_data[IRQ_N-1:0] = ien_q;
         default:            rd_data = '0;
      endcase
   end
endmodule

// File: rtl/tmr_core_chk.sv
module tmr_core_chk
   import tmr_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CTRL_W-1:0] ctrl,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  load,
   input logic              ovf_evt,
   input logic              match_evt,
   input logic              wr_cnt_hit,
   input logic              trig_hit,
   input logic              wr_ctrl_hit,
   input logic [IRQ_N-1:0]  ista,
   input logic              pwm,
   input logic              soft_go,
   input logic              busy
);
   // R1
   stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl[B_START] && !wr_cnt_hit && !trig_hit && !busy) |=> $stable(cnt));

   // R5
   strobe_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_hit && !busy) |=> (cnt == $past(load)));

   // R3
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_evt && ctrl[B_AUTO] && !busy) |=> (cnt == $past(load)));

   // R4
   one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_evt && !ctrl[B_AUTO] && !wr_ctrl_hit) |=> (!ctrl[B_START] && cnt == '0));

   // R8
   ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_evt && !busy) |=> ista[IRQ_OVF]);

   // R7
   match_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (match_evt && !busy) |=> ista[IRQ_MATCH]);

   // R11
   idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl[B_TOGGLE] && !ovf_evt && !match_evt && !busy)
         |=> (ctrl[B_TOGGLE] || pwm == ctrl[B_IDLE]));

   // R12
   soft_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_go |=> busy);
endmodule

bind tmr_core tmr_core_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ctrl(ctrl_q), .cnt(cnt), .load(load_q),
   .ovf_evt(ovf_evt), .match_evt(match_evt), .wr_cnt_hit(wr_cnt_hit),
   .trig_hit(trig_hit), .wr_ctrl_hit(wr_ctrl_hit), .ista(ista_q),
   .pwm(pwm_out), .soft_go(soft_go), .busy(busy)
);

// File: tb/tmr_core_tb.sv
module tmr_core_tb;
   localparam int CW = 32;
   localparam int AW = 4;
   localparam int RC = 4;
   // addresses and control bits, from the requirements
   localparam int A_RDY = 0, A_KEY = 1, A_CTRL = 2, A_CNT = 3, A_LOAD = 4;
   localparam int A_MATCH = 5, A_TRIG = 6, A_ISTAT = 7, A_IEN = 8;
   localparam int S_REG = 0, S_IRQ = 1, S_PWM = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [CW-1:0] wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [CW-1:0] rd_data;
   logic          irq, pwm_out;

   always #5 clk = ~clk;

   tmr_core #(.CNT_W(CW), .ADDR_W(AW), .RST_CYCLES(RC)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .irq(irq), .pwm_out(pwm_out)
   );

   typedef struct {
      int            src;
      logic [CW-1:0] exp;
      string         tag;
   } item_t;

   item_t q[$];
   event  go;
   int    n_chk = 0;
   int    n_fail = 0;
   bit    finished = 1'b0;

   task automatic wr(input int a, input logic [CW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
      @(posedge clk);
      #1 wr_en = 1'b0;
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // driver side: push expected item, then wake the monitor
   task automatic chk(input int src, input int a, input logic [CW-1:0] e,
                      input string tag);
      item_t it;
      rd_addr = AW'(a);
      #1;
      it.src = src; it.exp = e; it.tag = tag;
      q.push_back(it);
      -> go;
      #1;
   endtask

   // monitor side: pop and compare against the design's outputs
   initial begin
      item_t         it;
      logic [CW-1:0] act;
      forever begin
         @go;
         while (q.size() > 0) begin
            it = q.pop_front();
            if (it.src == S_IRQ)      act = CW'(irq);
            else if (it.src == S_PWM) act = CW'(pwm_out);
            else                      act = rd_data;
            n_chk++;
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
         end
      end
   end

   initial begin
      #1500000;
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [CW-1:0] c1;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      // R13 reset state
      chk(S_REG, A_RDY, 1, "R13 ready");
      chk(S_REG, A_CTRL, 0, "R13 ctrl");
      chk(S_REG, A_CNT, 0, "R13 count");
      cyc(1);
      chk(S_IRQ, 0, 0, "R13 irq");
      chk(S_PWM, 0, 0, "R13 pwm");

      // R6 direct write, R1 hold while stopped, then count
      wr(A_CNT, 100);
      chk(S_REG, A_CNT, 100, "R6 write");
      cyc(3);
      chk(S_REG, A_CNT, 100, "R1 stopped hold");
      wr(A_CTRL, 32'h1);
      cyc(5);
      chk(S_REG, A_CNT, 105, "R1 R6 live count");
      wr(A_CTRL, 0);
      rd_addr = AW'(A_CNT); #1 c1 = rd_data;
      cyc(4);
      chk(S_REG, A_CNT, c1, "R1 stop holds");

      // R2 prescaler N=1 -> every 4 clocks
      wr(A_CNT, 0);
      wr(A_CTRL, 32'h1 | (1 << 5) | (1 << 2));
      cyc(11);
      chk(S_REG, A_CNT, 2, "R2 N1 k11");
      cyc(1);
      chk(S_REG, A_CNT, 3, "R2 N1 k12");
      wr(A_CTRL, 0);
      wr(A_CNT, 0);
      wr(A_CTRL, 32'h1 | (1 << 5));
      cyc(7);
      chk(S_REG, A_CNT, 3, "R2 N0 k7");
      wr(A_CTRL, 0);
      wr(A_CNT, 0);
      wr(A_CTRL, 32'h1 | (2 << 2));
      cyc(5);
      chk(S_REG, A_CNT, 5, "R2 disabled divider");
      wr(A_CTRL, 0);

      // R5 reload strobe
      wr(A_LOAD, 32'h1234);
      wr(A_TRIG, 32'hDEAD);
      chk(S_REG, A_CNT, 32'h1234, "R5 strobe");

      // R4 one-shot overflow, R8 status, R9 irq
      wr(A_IEN, 2);
      wr(A_CNT, 32'hFFFF_FFFE);
      wr(A_CTRL, 32'h1);
      cyc(2);
      chk(S_REG, A_CNT, 0, "R4 wrap to zero");
      chk(S_REG, A_CTRL, 0, "R4 start cleared");
      cyc(3);
      chk(S_REG, A_CNT, 0, "R4 stays stopped");
      chk(S_REG, A_ISTAT, 2, "R8 ovf flag");
      chk(S_IRQ, 0, 1, "R9 irq on");
      wr(A_ISTAT, 1);
      chk(S_REG, A_ISTAT, 2, "R8 write zero keeps");
      wr(A_ISTAT, 2);
      chk(S_REG, A_ISTAT, 0, "R8 w1c");
      chk(S_IRQ, 0, 0, "R9 irq off");
      wr(A_IEN, 0);
      wr(A_CNT, 32'hFFFF_FFFF);
      wr(A_CTRL, 32'h1);
      cyc(1);
      chk(S_REG, A_ISTAT, 2, "R8 flag masked");
      chk(S_IRQ, 0, 0, "R9 masked");
      wr(A_IEN, 2);
      chk(S_IRQ, 0, 1, "R9 unmask");
      wr(A_ISTAT, 3);

      // R3 auto-reload
      wr(A_LOAD, 32'hFFFF_FFF0);
      wr(A_CNT, 32'hFFFF_FFFD);
      wr(A_CTRL, 32'h3);
      cyc(3);
      chk(S_REG, A_CNT, 32'hFFFF_FFF0, "R3 reload");
      chk(S_REG, A_CTRL, 3, "R3 keeps running");
      cyc(1);
      chk(S_REG, A_CNT, 32'hFFFF_FFF1, "R3 continues");
      wr(A_CTRL, 0);
      wr(A_ISTAT, 3);

      // R7 compare match
      wr(A_CNT, 10);
      wr(A_MATCH, 13);
      wr(A_IEN, 1);
      wr(A_CTRL, 32'h1 | (1 << 6));
      cyc(3);
      chk(S_REG, A_CNT, 13, "R7 count at match");
      chk(S_REG, A_ISTAT, 1, "R7 match flag");
      chk(S_IRQ, 0, 1, "R9 match irq");
      wr(A_CTRL, 0);
      wr(A_ISTAT, 3);
      wr(A_CNT, 10);
      wr(A_CTRL, 32'h1);
      cyc(3);
      chk(S_REG, A_CNT, 13, "R7 count no cmp");
      chk(S_REG, A_ISTAT, 0, "R7 cmp disabled");
      wr(A_CTRL, 0);
      wr(A_ISTAT, 3);

      // R10 toggle on overflow
      wr(A_LOAD, 32'hFFFF_FFFC);
      wr(A_CNT, 32'hFFFF_FFFC);
      wr(A_CTRL, 32'h3 | (1 << 10) | (1 << 12));
      cyc(3);
      chk(S_PWM, 0, 0, "R10 before event");
      cyc(1);
      chk(S_PWM, 0, 1, "R10 toggled");
      cyc(4);
      chk(S_PWM, 0, 0, "R10 toggled back");
      wr(A_CTRL, 0);
      wr(A_ISTAT, 3);

      // R11 pulse, idle high, overflow+match select
      wr(A_CNT, 0);
      wr(A_MATCH, 2);
      wr(A_CTRL, 32'h1 | (1 << 6) | (1 << 7) | (2 << 10));
      chk(S_PWM, 0, 1, "R11 idle high");
      cyc(2);
      chk(S_PWM, 0, 0, "R11 pulse");
      cyc(1);
      chk(S_PWM, 0, 1, "R11 pulse ends");
      wr(A_CTRL, 0);
      wr(A_CNT, 0);
      wr(A_CTRL, 32'h1 | (1 << 6) | (1 << 7) | (1 << 10));
      cyc(2);
      chk(S_PWM, 0, 1, "R10 ovf-only ignores match");
      wr(A_CTRL, 0);
      wr(A_ISTAT, 3);

      // R12 soft reset
      wr(A_LOAD, 55);
      wr(A_KEY, 2);
      chk(S_REG, A_RDY, 1, "R12 wrong key ready");
      chk(S_REG, A_LOAD, 55, "R12 wrong key keeps");
      wr(A_KEY, 6);
      chk(S_REG, A_RDY, 0, "R12 busy");
      cyc(3);
      chk(S_REG, A_RDY, 0, "R12 still busy");
      cyc(1);
      chk(S_REG, A_RDY, 1, "R12 ready again");
      chk(S_REG, A_LOAD, 0, "R12 cleared");

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule